// File: doc/BRIEF.md
# Dual-Bank Concurrent Access Manager

This block sits in front of a 1M-word flash array that is split into a small bank of 256K words and a large bank of 768K words. It decodes every read address and every write-start address to a bank, keeps one busy flag per bank, and decides cycle by cycle whether a read may be served from the array or must be answered with status. A read is served from the array when its bank is idle, even while the other bank is programming or erasing. At most one write (program, sector erase or block erase) may be in flight across the whole array.

A write-start request is granted or rejected in the cycle after it is presented. It is rejected when any bank is busy or when it targets one of the four outermost 2K-word sectors of the small bank while the write-protect input `wp_n` is low. On a grant the block records the target bank, the 2K-word sector index, the 32K-word block index and the operation code. These stay on the outputs for the timing engine that performs the operation. That engine ends the operation by pulsing `wr_done`. A build parameter chooses whether the small bank sits at the bottom or at the top of the address space.

Top module: `dbank_access_mgr`

## Requirements
- R1: With BOTTOM_SMALL=1, a word address below 0x40000 decodes to bank 0, the small bank, and every other address decodes to bank 1, the large bank. `rd_bank` shows the decode of `rd_addr` in the same cycle.
- R2: A read (`rd_en`=1) whose bank is idle gives `rd_grant`=1 and `status_select`=0 in the same cycle. This includes a read to the idle bank while the other bank is busy, and a read that arrives in the same cycle as a granted write-start request.
- R3: A read whose bank is busy gives `status_select`=1 and `rd_grant`=0 in the same cycle.
- R4: A write-start request (`wr_req`=1) to an unprotected address while both banks are idle produces a one-cycle `wr_grant` pulse in the next cycle. From that cycle on, `bank_busy` has exactly the bit of the target bank set (bit 0 is the small bank, bit 1 the large bank).
- R5: A bank's busy bit stays set until `wr_done` is sampled high, and it reads 0 from the following cycle. A `wr_done` pulse while both banks are idle has no effect, even in the same cycle as a granted request.
- R6: Any write-start request made while a bank is busy, including one made in the same cycle as `wr_done`, produces a one-cycle `wr_reject` pulse in the next cycle and leaves `bank_busy` unchanged. Both busy bits are never set together.
- R7: With `wp_n`=0, a write-start request to the four outermost sectors of the small bank is rejected. These are word addresses 0x00000 to 0x01FFF when BOTTOM_SMALL=1. With `wp_n`=1 the same request is granted, and addresses just outside that range are granted regardless of `wp_n`.
- R8: On a grant, `erase_sector` takes address bits [19:11], `erase_block` takes bits [19:15], `op_kind` takes the `wr_kind` code (0 program, 1 sector erase, 2 block erase) and `wr_bank` takes the target bank. All four hold their values until the next grant, and a rejected request does not change them.
- R9: After the synchronous reset, `bank_busy`, `wr_grant`, `wr_reject`, `erase_sector`, `erase_block`, `op_kind` and `wr_bank` are all zero.
- R10: With BOTTOM_SMALL=0, addresses from 0xC0000 up decode to bank 0, the small bank. The protected range becomes 0xFE000 to 0xFFFFF, and the lowest addresses are not protected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 20 | Read word address |
| rd_bank | output | 1 | Bank decoded from rd_addr (0 small, 1 large) |
| rd_grant | output | 1 | Read may be served from array data |
| status_select | output | 1 | Read must return operation status |
| wr_req | input | 1 | Write-start request |
| wr_addr | input | 20 | Target word address of the write |
| wr_kind | input | 2 | Operation code: 0 program, 1 sector erase, 2 block erase |
| wp_n | input | 1 | Low protects the outer sectors of the small bank |
| wr_done | input | 1 | End of the running internal operation |
| wr_grant | output | 1 | One-cycle pulse: request accepted |
| wr_reject | output | 1 | One-cycle pulse: request refused |
| wr_bank | output | 1 | Bank of the last granted write |
| erase_sector | output | 9 | 2K-word sector index of the last granted write |
| erase_block | output | 5 | 32K-word block index of the last granted write |
| op_kind | output | 2 | Operation code of the last granted write |
| bank_busy | output | 2 | Per-bank busy flags |

## Verification
Two cases matter most. In the first, a read and a write-start request arrive in the same cycle and target the same bank. The bench holds both strobes in one cycle and expects `rd_grant` before the edge, because the busy flag takes effect only at that edge, and `status_select` on the same held read after it. In the second, `wr_done` and a new request coincide. With a bank busy, the bench expects a reject and an idle array one cycle later. With both banks idle, it expects the stray done to be ignored and the request granted. Each case is judged from `bank_busy`, the grant and reject pulses, and the read outputs, sampled on the falling edge after the edge that registers them.

// File: rtl/dbank_pkg.sv
package dbank_pkg;

    // default geometry: word addressed, 1M words
    localparam int DEF_ADDR_W       = 20;
    localparam int DEF_SMALL_LOG2   = 18;   // 256K words in the small bank
    localparam int DEF_SECTOR_LOG2  = 11;   // 2K-word sectors
    localparam int DEF_BLOCK_LOG2   = 15;   // 32K-word erase blocks
    localparam int DEF_PROT_SECTORS = 4;

    localparam logic BANK_SMALL = 1'b0;
    localparam logic BANK_LARGE = 1'b1;

    typedef enum logic [1:0] {
        OP_PROGRAM      = 2'd0,
        OP_SECTOR_ERASE = 2'd1,
        OP_BLOCK_ERASE  = 2'd2,
        OP_RESERVED     = 2'd3
    } op_kind_e;

    // request accepted this cycle, and where it goes
    typedef struct packed {
        logic valid;
        logic bank;
    } busy_evt_t;

    function automatic logic [1:0] bank_mask(input logic bank);
        return bank ? 2'b10 : 2'b01;
    endfunction

endpackage

// File: rtl/dbank_decode.sv
module dbank_decode
    import dbank_pkg::*;
#(
    parameter int ADDR_W       = DEF_ADDR_W,
    parameter int SMALL_LOG2   = DEF_SMALL_LOG2,
    parameter bit BOTTOM_SMALL = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              bank
);
    localparam logic [ADDR_W:0] ONE         = 1;
    localparam logic [ADDR_W:0] SMALL_WORDS = ONE << SMALL_LOG2;
    localparam logic [ADDR_W:0] FULL_WORDS  = ONE << ADDR_W;

    logic [ADDR_W:0] ext_addr;
    assign ext_addr = {1'b0, addr};

    generate
        if (BOTTOM_SMALL) begin : g_bottom
            assign bank = (ext_addr < SMALL_WORDS) ? BANK_SMALL : BANK_LARGE;
        end else begin : g_top
            assign bank = (ext_addr >= (FULL_WORDS - SMALL_WORDS)) ? BANK_SMALL : BANK_LARGE;
        end
    endgenerate
endmodule

// File: rtl/dbank_busy.sv
module dbank_busy
    import dbank_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  busy_evt_t set_evt,
    input  logic      done,
    output logic [1:0] busy
);
    logic [1:0] set_mask;
    logic [1:0] busy_nxt;

    always_comb begin
        set_mask = set_evt.valid ? bank_mask(set_evt.bank) : 2'b00;
        // done only clears what is already running; a new start survives it
        busy_nxt = (busy & ~{2{done}}) | set_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 2'b00;
        end else begin
            busy <= busy_nxt;
        end
    end
endmodule

// File: rtl/dbank_write_gate.sv
module dbank_write_gate
    import dbank_pkg::*;
#(
    parameter int ADDR_W       = DEF_ADDR_W,
    parameter int SECTOR_LOG2  = DEF_SECTOR_LOG2,
    parameter int BLOCK_LOG2   = DEF_BLOCK_LOG2,
    parameter int PROT_SECTORS = DEF_PROT_SECTORS,
    parameter bit BOTTOM_SMALL = 1'b1,
    localparam int SECT_W      = ADDR_W - SECTOR_LOG2,
    localparam int BLK_W       = ADDR_W - BLOCK_LOG2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_kind,
    input  logic              wp_n,
    input  logic              tgt_bank,
    input  logic [1:0]        busy,
    output busy_evt_t         set_evt,
    output logic              wr_grant,
    output logic              wr_reject,
    output logic              wr_bank,
    output logic [SECT_W-1:0] erase_sector,
    output logic [BLK_W-1:0]  erase_block,
    output op_kind_e          op_kind
);
    localparam logic [ADDR_W:0] ONE        = 1;
    localparam logic [ADDR_W:0] PROT_WORDS = ONE * PROT_SECTORS << SECTOR_LOG2;
    localparam logic [ADDR_W:0] FULL_WORDS = ONE << ADDR_W;

    logic [ADDR_W:0] ext_addr;
    logic            in_outer;
    logic            locked;
    logic            accept;
    logic            refuse;

    assign ext_addr = {1'b0, wr_addr};

    generate
        if (BOTTOM_SMALL) begin : g_prot_bottom
            assign in_outer = ext_addr < PROT_WORDS;
        end else begin : g_prot_top
            assign in_outer = ext_addr >= (FULL_WORDS - PROT_WORDS);
        end
    endgenerate

    always_comb begin
        locked        = in_outer && !wp_n;
        refuse        = wr_req && ((busy != 2'b00) || locked);
        accept        = wr_req && !refuse;
        set_evt.valid = accept;
        set_evt.bank  = tgt_bank;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_grant     <= 1'b0;
            wr_reject    <= 1'b0;
            wr_bank      <= BANK_SMALL;
            erase_sector <= '0;
            erase_block  <= '0;
            op_kind      <= OP_PROGRAM;
        end else begin
            wr_grant  <= accept;
            wr_reject <= refuse;
            if (accept) begin
                wr_bank      <= tgt_bank;
                erase_sector <= wr_addr[ADDR_W-1:SECTOR_LOG2];
                erase_block  <= wr_addr[ADDR_W-1:BLOCK_LOG2];
                op_kind      <= op_kind_e'(wr_kind);
            end
        end
    end
endmodule

// File: rtl/dbank_access_mgr.sv
module dbank_access_mgr
    import dbank_pkg::*;
#(
    parameter int ADDR_W       = DEF_ADDR_W,
    parameter int SMALL_LOG2   = DEF_SMALL_LOG2,
    parameter int SECTOR_LOG2  = DEF_SECTOR_LOG2,
    parameter int BLOCK_LOG2   = DEF_BLOCK_LOG2,
    parameter int PROT_SECTORS = DEF_PROT_SECTORS,
    parameter bit BOTTOM_SMALL = 1'b1,
    localparam int SECT_W      = ADDR_W - SECTOR_LOG2,
    localparam int BLK_W       = ADDR_W - BLOCK_LOG2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_bank,
    output logic              rd_grant,
    output logic              status_select,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_kind,
    input  logic              wp_n,
    input  logic              wr_done,
    output logic              wr_grant,
    output logic              wr_reject,
    output logic              wr_bank,
    output logic [SECT_W-1:0] erase_sector,
    output logic [BLK_W-1:0]  erase_block,
    output logic [1:0]        op_kind,
    output logic [1:0]        bank_busy
);
    logic      wr_tgt_bank;
    busy_evt_t set_evt;
    op_kind_e  op_kind_q;

    dbank_decode #(
        .ADDR_W(ADDR_W), .SMALL_LOG2(SMALL_LOG2), .BOTTOM_SMALL(BOTTOM_SMALL)
    ) u_rd_dec (
        .addr(rd_addr), .bank(rd_bank)
    );

    dbank_decode #(
        .ADDR_W(ADDR_W), .SMALL_LOG2(SMALL_LOG2), .BOTTOM_SMALL(BOTTOM_SMALL)
    ) u_wr_dec (
        .addr(wr_addr), .bank(wr_tgt_bank)
    );

    dbank_write_gate #(
        .ADDR_W(ADDR_W), .SECTOR_LOG2(SECTOR_LOG2), .BLOCK_LOG2(BLOCK_LOG2),
        .PROT_SECTORS(PROT_SECTORS), .BOTTOM_SMALL(BOTTOM_SMALL)
    ) u_gate (
        .clk(clk), .rst(rst),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_kind(wr_kind), .wp_n(wp_n),
        .tgt_bank(wr_tgt_bank), .busy(bank_busy),
        .set_evt(set_evt),
        .wr_grant(wr_grant), .wr_reject(wr_reject), .wr_bank(wr_bank),
        .erase_sector(erase_sector), .erase_block(erase_block), .op_kind(op_kind_q)
    );

    dbank_busy u_busy (
        .clk(clk), .rst(rst),
        .set_evt(set_evt), .done(wr_done),
        .busy(bank_busy)
    );

    assign op_kind = op_kind_q;

    // read arbitration against the bank's own write, nothing else
    always_comb begin
        rd_grant      = rd_en && !bank_busy[rd_bank];
        status_select = rd_en &&  bank_busy[rd_bank];
    end
endmodule

// File: rtl/dbank_access_chk.sv
module dbank_access_chk #(
    parameter int ADDR_W       = 20,
    parameter int SECTOR_LOG2  = 11,
    parameter int PROT_SECTORS = 4,
    parameter bit BOTTOM_SMALL = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic              rd_bank,
    input logic              rd_grant,
    input logic              status_select,
    input logic              wr_req,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wp_n,
    input logic              wr_done,
    input logic              wr_grant,
    input logic              wr_reject,
    input logic              wr_bank,
    input logic [1:0]        bank_busy
);
    localparam logic [ADDR_W:0] ONE   = 1;
    localparam logic [ADDR_W:0] PROTW = ONE * PROT_SECTORS << SECTOR_LOG2;
    localparam logic [ADDR_W:0] FULLW = ONE << ADDR_W;

    logic outer_hit;
    generate
        if (BOTTOM_SMALL) begin : g_b
            assign outer_hit = {1'b0, wr_addr} < PROTW;
        end else begin : g_t
            assign outer_hit = {1'b0, wr_addr} >= (FULLW - PROTW);
        end
    endgenerate

    p_read_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !bank_busy[rd_bank]) |-> rd_grant);

    p_status_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(status_select && rd_grant));

    p_grant_busy_r4: assert property (@(posedge clk) disable iff (rst)
        wr_grant |-> bank_busy[wr_bank]);

    p_grant_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        wr_grant |=> !wr_grant);

    p_done_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_done && bank_busy != 2'b00) |=> (bank_busy == 2'b00));

    p_busy_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_req && bank_busy != 2'b00) |=> (wr_reject && !wr_grant));

    p_one_writer_r6: assert property (@(posedge clk) disable iff (rst)
        bank_busy != 2'b11);

    p_protect_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wp_n && outer_hit) |=> (wr_reject && !wr_grant));
endmodule

bind dbank_access_mgr dbank_access_chk #(
    .ADDR_W(ADDR_W), .SECTOR_LOG2(SECTOR_LOG2),
    .PROT_SECTORS(PROT_SECTORS), .BOTTOM_SMALL(BOTTOM_SMALL)
) chk_i (.*);

// File: tb/dbank_access_mgr_tb_top.sv
module dbank_access_mgr_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    // bottom-small instance
    logic        rd_en = 0, wr_req = 0, wp_n = 1, wr_done = 0;
    logic [19:0] rd_addr = 0, wr_addr = 0;
    logic [1:0]  wr_kind = 0;
    logic        rd_bank, rd_grant, status_select, wr_grant, wr_reject, wr_bank;
    logic [8:0]  erase_sector;
    logic [4:0]  erase_block;
    logic [1:0]  op_kind, bank_busy;

    // top-small instance
    logic        t_rd_en = 0, t_wr_req = 0, t_wp_n = 1, t_wr_done = 0;
    logic [19:0] t_rd_addr = 0, t_wr_addr = 0;
    logic        t_rd_bank, t_rd_grant, t_status, t_grant, t_reject, t_wbank;
    logic [8:0]  t_sector;
    logic [4:0]  t_block;
    logic [1:0]  t_kind, t_busy;

    dbank_access_mgr #(.BOTTOM_SMALL(1'b1)) dut_i (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_bank(rd_bank),
        .rd_grant(rd_grant), .status_select(status_select), .wr_req(wr_req),
        .wr_addr(wr_addr), .wr_kind(wr_kind), .wp_n(wp_n), .wr_done(wr_done),
        .wr_grant(wr_grant), .wr_reject(wr_reject), .wr_bank(wr_bank),
        .erase_sector(erase_sector), .erase_block(erase_block), .op_kind(op_kind),
        .bank_busy(bank_busy));

    dbank_access_mgr #(.BOTTOM_SMALL(1'b0)) dut_top_i (
        .clk(clk), .rst(rst), .rd_en(t_rd_en), .rd_addr(t_rd_addr), .rd_bank(t_rd_bank),
        .rd_grant(t_rd_grant), .status_select(t_status), .wr_req(t_wr_req),
        .wr_addr(t_wr_addr), .wr_kind(2'd1), .wp_n(t_wp_n), .wr_done(t_wr_done),
        .wr_grant(t_grant), .wr_reject(t_reject), .wr_bank(t_wbank),
        .erase_sector(t_sector), .erase_block(t_block), .op_kind(t_kind),
        .bank_busy(t_busy));

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic [19:0] addr;
        logic        wp;
        logic        bank;
        logic        grant;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{20'h00000, 1'b1, 1'b0, 1'b1},
        '{20'h01FFF, 1'b0, 1'b0, 1'b0},
        '{20'h01FFF, 1'b1, 1'b0, 1'b1},
        '{20'h02000, 1'b0, 1'b0, 1'b1},
        '{20'h3FFFF, 1'b0, 1'b0, 1'b1},
        '{20'h40000, 1'b0, 1'b1, 1'b1},
        '{20'hFFFFF, 1'b0, 1'b1, 1'b1},
        '{20'h12345, 1'b0, 1'b0, 1'b1}
    };

    // request held across one edge; outputs read at the following falling edge
    task automatic do_write(input logic [19:0] a, input logic [1:0] k, input logic done_too);
        @(negedge clk);
        wr_req = 1; wr_addr = a; wr_kind = k; wr_done = done_too;
        @(negedge clk);
        wr_req = 0; wr_done = 0;
    endtask

    task automatic finish_op();
        @(negedge clk);
        wr_done = 1;
        @(negedge clk);
        wr_done = 0;
    endtask

    task automatic t_write(input logic [19:0] a, input logic wp);
        @(negedge clk);
        t_wr_req = 1; t_wr_addr = a; t_wp_n = wp;
        @(negedge clk);
        t_wr_req = 0;
    endtask

    task automatic t_finish();
        @(negedge clk);
        t_wr_done = 1;
        @(negedge clk);
        t_wr_done = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state while reset is held
        chk("R9 busy", bank_busy, 0);
        chk("R9 grant", wr_grant, 0);
        chk("R9 reject", wr_reject, 0);
        chk("R9 sector", erase_sector, 0);
        chk("R9 block", erase_block, 0);
        chk("R9 kind", op_kind, 0);
        chk("R9 wbank", wr_bank, 0);
        rst = 0;

        // vector walk over decode, protection, capture and arbitration
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            wp_n = VECS[i].wp; rd_en = 1; rd_addr = VECS[i].addr;
            #1;
            chk("R1 rd_bank", rd_bank, VECS[i].bank);
            chk("R2 idle read", rd_grant, 1);
            rd_en = 0;
            do_write(VECS[i].addr, 2'(i % 3), 1'b0);
            chk("R4/R7 grant", wr_grant, VECS[i].grant);
            chk("R7 reject", wr_reject, !VECS[i].grant);
            if (VECS[i].grant) begin
                chk("R4 busy", bank_busy, VECS[i].bank ? 2 : 1);
                chk("R8 wbank", wr_bank, VECS[i].bank);
                chk("R8 sector", erase_sector, VECS[i].addr[19:11]);
                chk("R8 block", erase_block, VECS[i].addr[19:15]);
                chk("R8 kind", op_kind, i % 3);
                rd_en = 1; rd_addr = VECS[i].addr; #1;
                chk("R3 status", status_select, 1);
                chk("R3 no grant", rd_grant, 0);
                rd_addr = VECS[i].bank ? 20'h00000 : 20'h80000; #1;
                chk("R2 other bank", rd_grant, 1);
                rd_en = 0;
                @(negedge clk);
                chk("R4 pulse", wr_grant, 0);
                finish_op();
                chk("R5 cleared", bank_busy, 0);
            end else begin
                chk("R7 not busy", bank_busy, 0);
            end
        end

        // R6: everything refused while busy, captured fields held (R8)
        wp_n = 1;
        do_write(20'h50000, 2'd2, 1'b0);
        chk("R4 start", bank_busy, 2);
        do_write(20'h00100, 2'd0, 1'b0);
        chk("R6 other bank", wr_reject, 1);
        chk("R6 no grant", wr_grant, 0);
        chk("R6 busy kept", bank_busy, 2);
        chk("R8 held sector", erase_sector, 9'h0A0);
        chk("R8 held kind", op_kind, 2);
        do_write(20'h50800, 2'd1, 1'b0);
        chk("R6 same bank", wr_reject, 1);
        do_write(20'h00100, 2'd0, 1'b1);
        chk("R6 done+req reject", wr_reject, 1);
        chk("R5 done+req clear", bank_busy, 0);

        // R5: stray done with an idle array does not cancel a new grant
        do_write(20'h60000, 2'd0, 1'b1);
        chk("R5 stray done grant", wr_grant, 1);
        chk("R5 stray done busy", bank_busy, 2);
        finish_op();

        // R2/R3: read and write start in the same cycle, same bank
        @(negedge clk);
        rd_en = 1; rd_addr = 20'h70000; wr_req = 1; wr_addr = 20'h70000; wr_kind = 0;
        #1;
        chk("R2 same-cycle read", rd_grant, 1);
        @(negedge clk);
        wr_req = 0;
        #1;
        chk("R3 after start", status_select, 1);
        chk("R4 same-cycle grant", wr_grant, 1);
        rd_en = 0;
        finish_op();

        // R10: small bank at the top
        @(negedge clk);
        t_rd_en = 1; t_rd_addr = 20'hBFFFF; #1;
        chk("R10 below split", t_rd_bank, 1);
        t_rd_addr = 20'hC0000; #1;
        chk("R10 split", t_rd_bank, 0);
        t_rd_en = 0;
        t_write(20'hFE000, 1'b0);
        chk("R10 protected", t_reject, 1);
        chk("R10 protected busy", t_busy, 0);
        t_write(20'hFDFFF, 1'b0);
        chk("R10 outside", t_grant, 1);
        chk("R10 small busy", t_busy, 1);
        t_finish();
        t_write(20'h01000, 1'b0);
        chk("R10 low open", t_grant, 1);
        chk("R10 large busy", t_busy, 2);
        t_finish();
        chk("R10 clear", t_busy, 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule